// File: doc/BRIEF.md
# Two-Phase to Four-Phase Handshake Sequencer

This controller drives a four-phase (return-to-zero) function block from neighbours that talk in transitions. Three phase signals come in: one from the input completion tree, which toggles when a new data item has fully arrived, one from the output completion tree, which toggles when every output pair has taken the new phase, and the acknowledge toggle from the downstream stage. The block's own completion level comes in as well. The controller produces the level-sensitive enable that moves the function block between evaluate and return-to-zero, and the acknowledge toggle sent upstream.

Every transition input passes through a synchronizer. A change of level in either direction is turned into a one-cycle event, and that event sets a sticky pending flag. This replaces an asynchronous pulse generator and latch. Evaluation starts only when three things are true together: an input item is pending, the downstream stage has acknowledged the previous output, and the function block has finished its previous return-to-zero. The upstream acknowledge is toggled in the same cycle that enable drops, so the upstream stage can send its next item while the block is still resetting.

A parameter selects pipeline or server use. In server use no upstream acknowledge is produced and the downstream acknowledge is ignored.

Top module: `hs_phase_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `fb_enable` is 0 and `lack_phase` is 0.
- R2: `fb_enable` rises only when an unconsumed input transition is pending, the block completion (`fb_done`) has been low for at least the synchronizer latency, and (in pipeline mode) an unconsumed downstream acknowledge transition is pending. If any one of these is missing, enable stays low.
- R3: After reset the downstream acknowledge counts as already received, so the first input transition alone (with `fb_done` low) raises enable.
- R4: Once raised, `fb_enable` stays high until a transition on `out_phase` is seen. It then falls within SYNC_STAGES+2 cycles.
- R5: In pipeline mode `lack_phase` inverts in exactly the cycle `fb_enable` falls and at no other time, without waiting for `fb_done` to drop.
- R6: An input transition that arrives while the block is still resetting (`fb_done` high) is held. It starts the next evaluation once `fb_done` goes low.
- R7: Rising and falling transitions on the phase inputs are treated the same; each one is a single event.
- R8: A downstream acknowledge transition that arrives while enable is still high is held and satisfies the next evaluation.
- R9: With PIPELINE = 0, `lack_phase` stays 0 and `rack_phase` has no effect: evaluation needs only a pending input transition and `fb_done` low.
- R10: Each pending event is used by one evaluation only. An input transition raises enable once, and without a further input transition enable stays low.

Parameters: SYNC_STAGES (synchronizer depth, at least 2) and PIPELINE (1 = pipeline, 0 = server).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_phase | input | 1 | Aggregated input completion phase; each toggle is one new item |
| out_phase | input | 1 | Output completion phase; a toggle means all output pairs have the new phase |
| rack_phase | input | 1 | Acknowledge toggle from the downstream neighbour |
| fb_done | input | 1 | Four-phase completion level of the function block |
| fb_enable | output | 1 | Evaluate (1) / return-to-zero (0) enable to the function block |
| lack_phase | output | 1 | Acknowledge toggle to the upstream neighbour |

## Verification
The bench applies all six arrival orders of the three start conditions. For each order it checks that enable stays low until the last condition arrives. A design missing any term of the start condition would fire early in at least one order. It sends the input item and the downstream acknowledge during the reset phase or during evaluation, and checks that both are still honoured later. A design that dropped an unconsumed event would hang, and one that never cleared its flag would start a second evaluation with no new item. It also checks that the upstream acknowledge moves in the same cycle as the enable fall and at no other cycle, and that a server-mode instance ignores a stream of acknowledge toggles.

// File: rtl/hs_phase_seq_pkg.sv
// Shared types for the handshake sequencer.
package hs_phase_seq_pkg;

    // Sequencer phases: waiting to start, evaluating, returning to zero
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_EVAL = 2'd1,
        SQ_RZ   = 2'd2
    } seq_state_t;

endpackage

// File: rtl/hs_bit_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes: STAGES >= 2; the input changes slowly relative to clk.
module hs_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    // Shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], d_async};
    end

    assign q_sync = chain[LAST];
endmodule

// File: rtl/hs_toggle_detect.sv
// Turns a transition-signalled input into a one-cycle event pulse.
// A change in either direction produces one pulse.
// Assumes: the input sits at 0 during reset; toggles are spaced by more than
// one clock period.
module hs_toggle_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_async,
    output logic evt
);
    logic lvl;
    logic lvl_prev;

    hs_bit_sync #(.STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (phase_async),
        .q_sync  (lvl)
    );

    // Remember the last synchronized level to spot any change
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev <= 1'b0;
        else        lvl_prev <= lvl;
    end

    assign evt = lvl ^ lvl_prev;
endmodule

// File: rtl/hs_event_latch.sv
// Sticky set/reset flag that holds an event until it is consumed.
// If a set and a clear arrive in the same cycle, the set wins, so a new event
// arriving in the cycle of consumption is kept.
module hs_event_latch #(
    parameter bit INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr,
    output logic pend
);
    // Capture the event and keep it until cleared
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= INIT;
        else        pend <= set_evt | (pend & ~clr);
    end

    // A held event survives every cycle that does not consume it
    AST_EVENT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> pend);   // R6
endmodule

// File: rtl/hs_seq_core.sv
// Evaluate/return-to-zero sequencer for the function block.
// Starts evaluation on the three-way condition, ends it on output
// completion, and toggles the upstream acknowledge in that same cycle.
// Assumes: the pending flags come from hs_event_latch instances; done_s is
// the synchronized block completion level.
module hs_seq_core
    import hs_phase_seq_pkg::*;
#(
    parameter bit PIPELINE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_pend,
    input  logic ack_pend,
    input  logic out_pend,
    input  logic done_s,
    output logic take_start,
    output logic take_end,
    output logic fb_enable,
    output logic lack_phase
);
    seq_state_t state;
    seq_state_t state_nx;
    logic       ack_ok;

    // Downstream acknowledge is only part of the condition in pipeline mode
    assign ack_ok = PIPELINE ? ack_pend : 1'b1;

    // Decide when events are consumed and which phase comes next
    always_comb begin
        state_nx   = state;
        take_start = 1'b0;
        take_end   = 1'b0;
        case (state)
            SQ_IDLE: if (req_pend && ack_ok && !done_s) begin
                take_start = 1'b1;
                state_nx   = SQ_EVAL;
            end
            SQ_EVAL: if (out_pend) begin
                take_end = 1'b1;
                state_nx = SQ_RZ;
            end
            SQ_RZ:   if (!done_s) state_nx = SQ_IDLE;
            default: state_nx = SQ_IDLE;
        endcase
    end

    // Phase register and registered enable level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            fb_enable <= 1'b0;
        end else begin
            state <= state_nx;
            if (take_start)    fb_enable <= 1'b1;
            else if (take_end) fb_enable <= 1'b0;
        end
    end

    generate
        if (PIPELINE) begin : g_lack
            // Upstream acknowledge toggles as return-to-zero begins
            always_ff @(posedge clk) begin
                if (!rst_n)        lack_phase <= 1'b0;
                else if (take_end) lack_phase <= ~lack_phase;
            end

            AST_LACK_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
                (lack_phase != $past(lack_phase)) |-> $fell(fb_enable));   // R5
            AST_FALL_MOVES_LACK: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(fb_enable) |-> (lack_phase != $past(lack_phase)));   // R5
            AST_RISE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(fb_enable) |-> $past(ack_pend));   // R2
        end else begin : g_no_lack
            assign lack_phase = 1'b0;

            AST_SERVER_NO_LACK: assert property (@(posedge clk) disable iff (!rst_n)
                lack_phase == 1'b0);   // R9
        end
    endgenerate

    AST_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fb_enable) |-> $past(req_pend));   // R2
    AST_RISE_NEEDS_RZ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fb_enable) |-> !$past(done_s));   // R2
    AST_FALL_NEEDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fb_enable) |-> $past(out_pend));   // R4
    AST_ENABLE_TRACKS_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        fb_enable == (state == SQ_EVAL));   // R4
endmodule

// File: rtl/hs_phase_seq.sv
// Top of the handshake sequencer: synchronizes the transition inputs,
// holds each event in a sticky flag, and runs the evaluate/return-to-zero
// sequence for a four-phase function block.
// Assumes: all phase inputs are 0 at reset; the block completion level rises
// during evaluation and falls during return-to-zero.
module hs_phase_seq #(
    parameter int SYNC_STAGES = 2,
    parameter bit PIPELINE    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_phase,
    input  logic out_phase,
    input  logic rack_phase,
    input  logic fb_done,
    output logic fb_enable,
    output logic lack_phase
);
    logic in_evt, out_evt, rack_evt;
    logic req_pend, ack_pend, out_pend;
    logic done_s;
    logic take_start, take_end;

    hs_toggle_detect #(.STAGES(SYNC_STAGES)) u_in_det (
        .clk (clk), .rst_n (rst_n), .phase_async (in_phase),   .evt (in_evt)
    );
    hs_toggle_detect #(.STAGES(SYNC_STAGES)) u_out_det (
        .clk (clk), .rst_n (rst_n), .phase_async (out_phase),  .evt (out_evt)
    );
    hs_toggle_detect #(.STAGES(SYNC_STAGES)) u_rack_det (
        .clk (clk), .rst_n (rst_n), .phase_async (rack_phase), .evt (rack_evt)
    );

    hs_bit_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk (clk), .rst_n (rst_n), .d_async (fb_done), .q_sync (done_s)
    );

    // New input item: consumed when evaluation starts
    hs_event_latch #(.INIT(1'b0)) u_req_flag (
        .clk (clk), .rst_n (rst_n), .set_evt (in_evt),   .clr (take_start), .pend (req_pend)
    );
    // Downstream acknowledge: counts as already received after reset
    hs_event_latch #(.INIT(1'b1)) u_ack_flag (
        .clk (clk), .rst_n (rst_n), .set_evt (rack_evt), .clr (take_start), .pend (ack_pend)
    );
    // Output completion: consumed when evaluation ends
    hs_event_latch #(.INIT(1'b0)) u_out_flag (
        .clk (clk), .rst_n (rst_n), .set_evt (out_evt),  .clr (take_end),   .pend (out_pend)
    );

    hs_seq_core #(.PIPELINE(PIPELINE)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_pend   (req_pend),
        .ack_pend   (ack_pend),
        .out_pend   (out_pend),
        .done_s     (done_s),
        .take_start (take_start),
        .take_end   (take_end),
        .fb_enable  (fb_enable),
        .lack_phase (lack_phase)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!fb_enable && !lack_phase));   // R1
endmodule

// File: tb/hs_phase_seq_bench.sv
module hs_phase_seq_bench;
    localparam int SYNC  = 2;
    localparam int LATE  = SYNC + 6;   // generous bound on response cycles
    localparam int QUIET = 12;         // cycles a missing condition is held

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_ph = 1'b0, out_ph = 1'b0, rack_ph = 1'b0, done = 1'b0;
    logic s_in = 1'b0, s_out = 1'b0, s_rack = 1'b0, s_done = 1'b0;
    logic en, lack, s_en, s_lack;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    hs_phase_seq #(.SYNC_STAGES(SYNC), .PIPELINE(1'b1)) u_hs_phase_seq (
        .clk (clk), .rst_n (rst_n), .in_phase (in_ph), .out_phase (out_ph),
        .rack_phase (rack_ph), .fb_done (done), .fb_enable (en), .lack_phase (lack)
    );
    hs_phase_seq #(.SYNC_STAGES(SYNC), .PIPELINE(1'b0)) u_hs_phase_seq_srv (
        .clk (clk), .rst_n (rst_n), .in_phase (s_in), .out_phase (s_out),
        .rack_phase (s_rack), .fb_done (s_done), .fb_enable (s_en), .lack_phase (s_lack)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Step one clock and sample away from the edge
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    function automatic logic sel_en(input bit srv);
        return srv ? s_en : en;
    endfunction

    // Enable must stay at its present level for n cycles
    task automatic hold_level(input bit srv, input logic want, input int n, input string req);
        bit ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            tick(1);
            if (sel_en(srv) != want) ok = 1'b0;
        end
        check(ok, req, sel_en(srv), want);
    endtask

    // Enable must reach a level within LATE cycles
    task automatic reach_level(input bit srv, input logic want, input string req);
        int n = 0;
        while (sel_en(srv) != want && n < LATE) begin
            tick(1);
            n++;
        end
        check(sel_en(srv) == want, req, sel_en(srv), want);
    endtask

    // Wait for the enable fall; the upstream acknowledge must move in that cycle only
    task automatic fall_with_ack(input bit srv, input logic lack_exp, input string req);
        int   n = 0;
        logic l0 = srv ? s_lack : lack;
        logic l;
        while (sel_en(srv) && n < LATE) begin
            tick(1);
            n++;
            l = srv ? s_lack : lack;
            if (sel_en(srv) && l != l0)
                check(1'b0, req, l, l0);   // moved early
        end
        l = srv ? s_lack : lack;
        check(!sel_en(srv), req, sel_en(srv), 0);
        check(l == lack_exp, req, l, lack_exp);
    endtask

    // Finish one pipeline evaluation: completion high, output phase toggles
    task automatic finish_eval(input logic lack_exp, input string req);
        done = 1'b1;
        tick(4);
        out_ph = ~out_ph;
        fall_with_ack(1'b0, lack_exp, req);
    endtask

    // The position of each start condition in arrival order p (0..5)
    function automatic int order_of(input int p, input int step);
        int a, b, c;
        a = p / 2;
        b = (a == 0) ? 1 : 0;
        c = 3 - a - b;
        if (p % 2 == 1) begin
            int t = b;
            b = c;
            c = t;
        end
        return (step == 0) ? a : (step == 1) ? b : c;
    endfunction

    initial begin
        #500000;
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic lk = 1'b0;
        tick(3);
        // R1: reset state
        check(en == 1'b0 && lack == 1'b0, "R1", {en, lack}, 0);
        check(s_en == 1'b0 && s_lack == 1'b0, "R1", {s_en, s_lack}, 0);
        rst_n = 1'b1;
        tick(1);
        check(en == 1'b0 && lack == 1'b0, "R1", {en, lack}, 0);

        // R2: no input item, no evaluation
        hold_level(1'b0, 1'b0, QUIET, "R2");

        // R3 and R7 (rising): the first item needs no downstream acknowledge
        in_ph = 1'b1;
        reach_level(1'b0, 1'b1, "R3");
        check(lack == 1'b0, "R3", lack, 0);

        // R4: enable holds until the output phase moves
        hold_level(1'b0, 1'b1, QUIET, "R4");
        done = 1'b1;
        hold_level(1'b0, 1'b1, 6, "R4");
        out_ph = ~out_ph;
        lk = ~lk;
        fall_with_ack(1'b0, lk, "R5");

        // R6, R7 (falling): item and acknowledge arrive while still resetting
        tick(2);
        in_ph = 1'b0;
        rack_ph = ~rack_ph;
        hold_level(1'b0, 1'b0, QUIET, "R6");
        done = 1'b0;
        reach_level(1'b0, 1'b1, "R6");

        lk = ~lk;
        finish_eval(lk, "R5");
        done = 1'b0;
        // R2: input pending but no downstream acknowledge
        in_ph = ~in_ph;
        hold_level(1'b0, 1'b0, QUIET, "R2");
        rack_ph = ~rack_ph;
        reach_level(1'b0, 1'b1, "R2");

        // R8: acknowledge arrives during evaluation and is held
        tick(2);
        rack_ph = ~rack_ph;
        tick(6);
        lk = ~lk;
        finish_eval(lk, "R8");
        done = 1'b0;
        in_ph = ~in_ph;
        reach_level(1'b0, 1'b1, "R8");

        // R10: acknowledge present but no new item -> no second evaluation
        lk = ~lk;
        finish_eval(lk, "R5");
        done = 1'b0;
        rack_ph = ~rack_ph;
        hold_level(1'b0, 1'b0, QUIET, "R10");
        in_ph = ~in_ph;
        reach_level(1'b0, 1'b1, "R10");
        lk = ~lk;
        finish_eval(lk, "R5");

        // R2: every arrival order of the three start conditions
        for (int p = 0; p < 6; p++) begin
            for (int s = 0; s < 3; s++) begin
                case (order_of(p, s))
                    0: in_ph = ~in_ph;
                    1: rack_ph = ~rack_ph;
                    default: done = 1'b0;
                endcase
                if (s < 2) hold_level(1'b0, 1'b0, QUIET, "R2");
                else       reach_level(1'b0, 1'b1, "R2");
            end
            lk = ~lk;
            finish_eval(lk, "R5");
        end
        done = 1'b0;

        // R9: server mode ignores the downstream acknowledge
        for (int k = 0; k < 4; k++) begin
            s_rack = ~s_rack;
            tick(3);
        end
        hold_level(1'b1, 1'b0, QUIET, "R9");
        s_in = 1'b1;
        reach_level(1'b1, 1'b1, "R9");
        s_done = 1'b1;
        tick(4);
        s_out = ~s_out;
        fall_with_ack(1'b1, 1'b0, "R9");
        s_done = 1'b0;
        s_in = 1'b0;
        reach_level(1'b1, 1'b1, "R9");
        check(s_lack == 1'b0, "R9", s_lack, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule